// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a programmable sum-of-products logic device. It takes the OR-sum produced by the product-term plane and delivers it to a bidirectional pin. Two configuration bits shape the path. One picks whether the pin shows a clocked copy of the sum held in a D flip-flop or shows the sum directly. The other picks whether the pin value is inverted.

The flip-flop shares the device clock with its neighbours. It is cleared at once by a global asynchronous clear and by a power-up clear on a clock edge. A global preset sets it on a clock edge. In test mode it can also be loaded with a value supplied from outside.

A separate product term enables the pin driver. While that term is false the pin is left undriven, so an external source can use it as an input. A feedback bit goes back to the array. In registered mode the feedback is the register's true output. In combinational mode it is the level on the pin.

Top module: `outcell`

## Requirements
- R1: With `cfg_reg`=1 the register takes `sop_in` on each rising `clk` edge when no clear, preset or test load is active, and the pin shows the register after that edge.
- R2: With `cfg_reg`=0 the pin follows `sop_in` combinationally, with no clock edge needed.
- R3: With `cfg_inv`=1 the driven pin value is the complement of the selected source (register or `sop_in`). With `cfg_inv`=0 it is the source itself.
- R4: A high `clr_async` forces the register to 0 at once, without a clock edge, and keeps it at 0 across edges whatever the other controls are.
- R5: A high `set_sync` (no clear, no test load) sets the register to 1 on the next rising edge, and only on that edge.
- R6: A high `pwr_clr` clears the register on the next rising edge and outranks test load and preset. Only `clr_async` outranks it.
- R7: With `tst_mode`=1 the register takes `tst_val` on the next rising edge, overriding both `sop_in` and `set_sync`.
- R8: The cell drives `pad_io` only while `oe_term`=1. Otherwise an external level on `pad_io` is undisturbed and, in combinational mode, appears on `fb_out`.
- R9: In registered mode `fb_out` equals the uninverted register value, whatever `oe_term` and `cfg_inv` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock |
| pwr_clr | input | 1 | Power-up clear, synchronous, active high |
| clr_async | input | 1 | Global asynchronous clear, active high |
| set_sync | input | 1 | Global synchronous preset, active high |
| cfg_reg | input | 1 | 1 = registered path, 0 = combinational path |
| cfg_inv | input | 1 | 1 = invert pin value, 0 = pass through |
| sop_in | input | 1 | OR-sum from the product-term plane |
| oe_term | input | 1 | Output-enable product term |
| tst_mode | input | 1 | Test load enable |
| tst_val | input | 1 | Value loaded in test mode |
| pad_io | inout | 1 | Bidirectional device pin |
| fb_out | output | 1 | Feedback bit to the product-term plane |

## Verification
The register is observable only through the pin and the feedback bit. A wrong stored value therefore shows up in the cycle after the faulty edge: on `pad_io`, possibly inverted, when the driver is on, and on `fb_out` in registered mode even when the pin is undriven.

A wrong priority among clear, power-up clear, test load and preset shows up one edge after the controls are raised together. A broken asynchronous clear shows up within nanoseconds, before any edge. Mistakes in the polarity or path selection appear combinationally, so every mode is compared against the reference every cycle.

// File: rtl/outcell_pkg.sv
package outcell_pkg;

    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_INV  = 1'b1
    } pol_e;

    typedef struct packed {
        path_e path;
        pol_e  pol;
    } cell_cfg_t;

    typedef enum logic [1:0] {
        SRC_DATA = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_TEST = 2'd2,
        SRC_ZERO = 2'd3
    } load_src_e;

    // Synchronous load priority: power-up clear, then test load, then preset.
    function automatic load_src_e pick_src(input logic pclr, input logic tmode,
                                           input logic pset);
        if (pclr)
            return SRC_ZERO;
        else if (tmode)
            return SRC_TEST;
        else if (pset)
            return SRC_ONE;
        else
            return SRC_DATA;
    endfunction

    function automatic logic apply_pol(input logic v, input pol_e p);
        return (p == POL_INV) ? ~v : v;
    endfunction

endpackage

// File: rtl/oc_store.sv
module oc_store
    import outcell_pkg::*;
(
    input  logic clk,
    input  logic pwr_clr,
    input  logic clr_async,
    input  logic set_sync,
    input  logic tst_mode,
    input  logic tst_val,
    input  logic d,
    output logic q
);

    load_src_e src;
    logic      nxt;

    always_comb begin
        src = pick_src(pwr_clr, tst_mode, set_sync);
        case (src)
            SRC_ZERO: nxt = 1'b0;
            SRC_TEST: nxt = tst_val;
            SRC_ONE:  nxt = 1'b1;
            default:  nxt = d;
        endcase
    end

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async)
            q <= 1'b0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/oc_route.sv
module oc_route
    import outcell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sop,
    input  logic      q,
    input  logic      pad_in,
    output logic      drive_val,
    output logic      fb
);

    logic pre;

    always_comb begin
        pre       = (cfg.path == PATH_REG) ? q : sop;
        drive_val = apply_pol(pre, cfg.pol);
        fb        = (cfg.path == PATH_REG) ? q : pad_in;
    end

endmodule

// File: rtl/oc_pad.sv
module oc_pad (
    input  logic oe,
    input  logic val,
    inout  wire  pad,
    output logic pad_in
);

    assign pad    = oe ? val : 1'bz;
    assign pad_in = pad;

endmodule

// File: rtl/outcell.sv
module outcell
    import outcell_pkg::*;
(
    input  logic clk,
    input  logic pwr_clr,
    input  logic clr_async,
    input  logic set_sync,
    input  logic cfg_reg,
    input  logic cfg_inv,
    input  logic sop_in,
    input  logic oe_term,
    input  logic tst_mode,
    input  logic tst_val,
    inout  wire  pad_io,
    output logic fb_out
);

    cell_cfg_t cfg;
    logic      q_r;
    logic      drv_val;
    logic      pad_rd;

    assign cfg.path = cfg_reg ? PATH_REG : PATH_COMB;
    assign cfg.pol  = cfg_inv ? POL_INV : POL_TRUE;

    oc_store u_store (
        .clk       (clk),
        .pwr_clr   (pwr_clr),
        .clr_async (clr_async),
        .set_sync  (set_sync),
        .tst_mode  (tst_mode),
        .tst_val   (tst_val),
        .d         (sop_in),
        .q         (q_r)
    );

    oc_route u_route (
        .cfg       (cfg),
        .sop       (sop_in),
        .q         (q_r),
        .pad_in    (pad_rd),
        .drive_val (drv_val),
        .fb        (fb_out)
    );

    oc_pad u_pad (
        .oe     (oe_term),
        .val    (drv_val),
        .pad    (pad_io),
        .pad_in (pad_rd)
    );

endmodule

// File: rtl/outcell_chk.sv
module outcell_chk (
    input logic clk,
    input logic pwr_clr,
    input logic clr_async,
    input logic set_sync,
    input logic cfg_reg,
    input logic cfg_inv,
    input logic sop_in,
    input logic oe_term,
    input logic tst_mode,
    input logic tst_val,
    input logic q_r,
    input logic pad,
    input logic fb_out
);

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (pwr_clr)
        (!clr_async && !tst_mode && !set_sync) |=> (clr_async || q_r == $past(sop_in))); // R1

    AST_COMB_PIN: assert property (@(posedge clk) disable iff (pwr_clr)
        (oe_term && !cfg_reg) |-> (pad == (sop_in ^ cfg_inv))); // R2

    AST_REG_PIN_POL: assert property (@(posedge clk) disable iff (pwr_clr)
        (oe_term && cfg_reg) |-> (pad == (q_r ^ cfg_inv))); // R3

    AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (pwr_clr)
        clr_async |-> !q_r); // R4

    AST_PRESET_EDGE: assert property (@(posedge clk) disable iff (pwr_clr)
        (!clr_async && !tst_mode && set_sync) |=> (clr_async || q_r)); // R5

    AST_PWR_CLEAR: assert property (@(posedge clk) disable iff (clr_async)
        pwr_clr |=> !q_r); // R6

    AST_TEST_LOAD: assert property (@(posedge clk) disable iff (pwr_clr)
        (!clr_async && tst_mode) |=> (clr_async || q_r == $past(tst_val))); // R7

    AST_REG_FEEDBACK: assert property (@(posedge clk) disable iff (pwr_clr)
        cfg_reg |-> (fb_out == q_r)); // R9

endmodule

bind outcell outcell_chk u_chk (
    .clk       (clk),
    .pwr_clr   (pwr_clr),
    .clr_async (clr_async),
    .set_sync  (set_sync),
    .cfg_reg   (cfg_reg),
    .cfg_inv   (cfg_inv),
    .sop_in    (sop_in),
    .oe_term   (oe_term),
    .tst_mode  (tst_mode),
    .tst_val   (tst_val),
    .q_r       (q_r),
    .pad       (pad_io),
    .fb_out    (fb_out)
);

// File: tb/test_outcell.sv
`timescale 1ns/1ps
module test_outcell;

    logic clk = 1'b0;
    logic pwr_clr = 1'b1, clr_async = 1'b0, set_sync = 1'b0;
    logic cfg_reg = 1'b1, cfg_inv = 1'b0, sop_in = 1'b0, oe_term = 1'b1;
    logic tst_mode = 1'b0, tst_val = 1'b0;
    logic ext_val = 1'b0;
    wire  pad_io;
    logic fb_out;

    int   n_chk = 0, n_bad = 0;
    logic mq = 1'b0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    assign pad_io = (!oe_term) ? ext_val : 1'bz;

    outcell i_outcell (
        .clk(clk), .pwr_clr(pwr_clr), .clr_async(clr_async), .set_sync(set_sync),
        .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .sop_in(sop_in), .oe_term(oe_term),
        .tst_mode(tst_mode), .tst_val(tst_val), .pad_io(pad_io), .fb_out(fb_out)
    );

    task automatic check(input string tag);
        logic src, ep, ef;
        src = cfg_reg ? mq : sop_in;
        ep  = oe_term ? (src ^ cfg_inv) : ext_val;
        ef  = cfg_reg ? mq : ep;
        n_chk++;
        if (pad_io !== ep || fb_out !== ef) begin
            n_bad++;
            $display("FAIL %s: pad=%b fb=%b expected pad=%b fb=%b", tag, pad_io, fb_out, ep, ef);
        end
    endtask

    // One clock: the reference register advances at the edge, outputs compared at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        if (clr_async)     mq = 1'b0;
        else if (pwr_clr)  mq = 1'b0;
        else if (tst_mode) mq = tst_val;
        else if (set_sync) mq = 1'b1;
        else               mq = sop_in;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] pat = 16'hB36A;
        // R6: reset state through the registered pin
        step("R6 reset"); step("R6 reset");
        pwr_clr = 1'b0;

        // R1: registered capture
        for (int i = 0; i < 16; i++) begin sop_in = pat[i]; step("R1 capture"); end
        // R3: inverted registered output
        cfg_inv = 1'b1;
        for (int i = 0; i < 8; i++) begin sop_in = pat[15-i]; step("R3 reg invert"); end
        // R2: combinational, both polarities; also checked mid-cycle
        cfg_reg = 1'b0;
        for (int p = 0; p < 2; p++) begin
            cfg_inv = p[0];
            for (int i = 0; i < 6; i++) begin
                sop_in = pat[i+3];
                step("R2 comb");
                sop_in = ~sop_in; #3 check("R2 comb no edge");
            end
        end
        // R5: preset with data low
        cfg_reg = 1'b1; cfg_inv = 1'b0; sop_in = 1'b0; step("R1 clear to 0");
        set_sync = 1'b1; #3 check("R5 no change before edge");
        step("R5 preset"); step("R5 preset hold");
        set_sync = 1'b0; step("R1 after preset");
        // R7: test load beats preset and data
        tst_mode = 1'b1; set_sync = 1'b1;
        for (int i = 0; i < 6; i++) begin tst_val = pat[i]; sop_in = ~pat[i]; step("R7 preload"); end
        // R4: asynchronous clear mid-cycle, then held across edges
        tst_val = 1'b1; step("R7 preload one");
        clr_async = 1'b1; #2 mq = 1'b0; check("R4 async clear");
        step("R4 clear hold"); step("R4 clear hold");
        clr_async = 1'b0; tst_mode = 1'b0; set_sync = 1'b0; sop_in = 1'b1; step("R1 after clear");
        // R6: power-up clear outranks test load and preset
        pwr_clr = 1'b1; tst_mode = 1'b1; tst_val = 1'b1; set_sync = 1'b1; step("R6 priority");
        pwr_clr = 1'b0; tst_mode = 1'b0; set_sync = 1'b0;
        // R8: pin undriven, external level in combinational mode
        oe_term = 1'b0; cfg_reg = 1'b0;
        for (int i = 0; i < 6; i++) begin ext_val = pat[i+5]; sop_in = ~pat[i+5]; step("R8 input pin"); end
        // R9: registered feedback with pin undriven and inverted
        cfg_reg = 1'b1; cfg_inv = 1'b1;
        for (int i = 0; i < 8; i++) begin sop_in = pat[i+2]; ext_val = pat[i]; step("R9 reg feedback"); end
        oe_term = 1'b1;
        for (int i = 0; i < 4; i++) begin sop_in = pat[i+8]; step("R9 reg feedback driven"); end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule